// File: doc/BRIEF.md
# Set-Associative Read Cache Controller

This block is a small four-way set-associative cache placed between a processor request port and a slower word-wide main-memory port. Read requests that find their block in local storage are answered one cycle after acceptance with no memory traffic. A read that misses fetches the whole four-word block from main memory, one word per memory transfer, and answers only after the last word has arrived. The victim way is an empty way if the set has one, otherwise the way named by a three-bit tree pseudo-LRU state that is kept per set.

Writes never allocate. A write whose block is absent is passed to main memory as a single word write. A write that hits updates the cached word and marks the block modified. Memory sees that data only when the block is later chosen as a victim, and then the whole block is written back, word by word, before the refill of the new block begins. The processor port is a valid/ready request with a one-cycle response pulse. The memory port issues one word request at a time and holds it until the memory acknowledges, which may take any number of cycles.

Top module: `sa_read_cache`

## Requirements
- R1: A read whose block is present raises `cpu_resp_valid` in the cycle after acceptance, with the stored word on `cpu_resp_rdata`, and issues no memory request.
- R2: A read miss issues four memory reads, at word offsets 0, 1, 2, 3 of the block in that order (memory address = tag, set, offset, byte bits 00). It responds with the requested word one cycle after the last acknowledge, and `cpu_req_ready` is low until then.
- R3: On a miss, the lowest-numbered invalid way of the set is the victim. If every way is valid, the per-set tree bits t[2:0] choose the victim: t0=0 selects way t1 (0 or 1), and t0=1 selects way 2+t2. Every hit and every fill of way w sets t0 to the opposite half, and sets the pair bit of that half to point at the other way of the pair.
- R4: A write miss issues exactly one memory write of the word and responds one cycle after its acknowledge. It brings no block into the cache, so a later read of that block misses.
- R5: A write hit updates the cached word, responds in the cycle after acceptance and issues no memory request.
- R6: If the victim was modified, its four words are written to memory at offsets 0 to 3 of its old address, and this happens before the first refill read. A clean victim causes no memory write.
- R7: Address bits [1:0] are ignored. Bits [3:2] select the word, bits [7:4] select the set and bits [15:8] form the tag.
- R8: Once `mem_req_valid` is raised, the request (valid, write flag, address, write data) stays unchanged until the cycle in which `mem_ack` is high.
- R9: A synchronous active-low reset invalidates every block and clears every modified flag. After it, the block is idle and ready, and every read misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 16 | Byte address of the request |
| cpu_req_wdata | input | 32 | Write data |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | 32 | Read data (0 for writes) |
| mem_req_valid | output | 1 | Memory word request pending |
| mem_req_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | 16 | Word-aligned memory byte address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the pending request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The hardest case to reach is eviction of a modified block that the replacement tree, and not an empty way, has chosen. A set must first be filled completely, one of its blocks written while resident, and the other ways touched in an order that steers the tree onto the dirty way. A directed sequence does exactly this, with the expected victim worked out by hand. It is followed by a long random run over a few tags per set with varying memory latency, in which a behavioural cache model in the bench predicts every memory transfer and every read value.

// File: rtl/sac_pkg.sv
// Shared definitions for the set-associative read cache.
// Assumes a fixed associativity of four ways, so the replacement state
// is a three-bit binary tree per set.
package sac_pkg;

    localparam int NUM_WAYS = 4;
    localparam int WAY_W    = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_WTHRU
    } ctl_state_e;

    // Tree bit 0 picks the half, bits 1 and 2 pick a way inside a half.
    function automatic logic [WAY_W-1:0] tree_victim(input logic [2:0] t);
        if (!t[0]) return {1'b0, t[1]};
        return {1'b1, t[2]};
    endfunction

    // Point the tree away from the way that was just used.
    function automatic logic [2:0] tree_touch(input logic [2:0] t, input logic [WAY_W-1:0] w);
        logic [2:0] n;
        n = t;
        if (!w[1]) begin
            n[0] = 1'b1;
            n[1] = ~w[0];
        end else begin
            n[0] = 1'b0;
            n[2] = ~w[0];
        end
        return n;
    endfunction

endpackage

// File: rtl/sac_tag_store.sv
// Tag, valid and modified storage for all sets and ways.
// Lookup is combinational on one set; fill and dirty-mark are written
// on the clock. Assumes fill and dirty-mark never target the same entry
// in one cycle.
module sac_tag_store
    import sac_pkg::*;
#(
    parameter  int SETS  = 16,
    parameter  int TAG_W = 8,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic [NUM_WAYS-1:0] hit_vec,
    output logic [NUM_WAYS-1:0] valid_vec,
    output logic [NUM_WAYS-1:0] dirty_vec,
    output logic [TAG_W-1:0] way_tag [NUM_WAYS],
    input  logic             fill_en,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             dirty_en,
    input  logic [SET_W-1:0] dirty_set,
    input  logic [WAY_W-1:0] dirty_way
);

    logic [TAG_W-1:0]    tag_q [SETS][NUM_WAYS];
    logic [NUM_WAYS-1:0] val_q [SETS];
    logic [NUM_WAYS-1:0] drt_q [SETS];

    // Valid and modified flags: cleared by reset, set by fill / write hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                val_q[s] <= '0;
                drt_q[s] <= '0;
            end
        end else begin
            if (fill_en) begin
                val_q[fill_set][fill_way] <= 1'b1;
                drt_q[fill_set][fill_way] <= 1'b0;
            end
            if (dirty_en) begin
                drt_q[dirty_set][dirty_way] <= 1'b1;
            end
        end
    end

    // Tag field written on fill; no reset needed behind the valid flag.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_set][fill_way] <= fill_tag;
        end
    end

    assign valid_vec = val_q[lk_set];
    assign dirty_vec = drt_q[lk_set];

    // One comparator per way.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign way_tag[w] = tag_q[lk_set][w];
        assign hit_vec[w] = val_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
    end

endmodule

// File: rtl/sac_data_store.sv
// Word storage for every block: one combinational read port and one
// clocked write port, indexed by {set, way, word}. Contents are not reset.
module sac_data_store #(
    parameter  int DEPTH  = 256,
    parameter  int DATA_W = 32,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] word_q [DEPTH];

    // Store one word when asked.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = word_q[rd_idx];

endmodule

// File: rtl/sac_lru_state.sv
// Per-set tree pseudo-LRU state with a victim read port and one update
// port. Reset returns every tree to all zeros.
module sac_lru_state
    import sac_pkg::*;
#(
    parameter  int SETS  = 16,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] victim_way,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way
);

    logic [2:0] tree_q [SETS];

    // Update the tree of the touched set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (touch_en) begin
            tree_q[touch_set] <= tree_touch(tree_q[touch_set], touch_way);
        end
    end

    assign victim_way = tree_victim(tree_q[rd_set]);

endmodule

// File: rtl/sa_read_cache.sv
// Four-way set-associative cache controller with read allocation,
// write-no-allocate misses and write-back of modified victims.
// Assumes one outstanding processor request and one outstanding memory
// word request at a time; memory acknowledges with a one-cycle pulse.
module sa_read_cache
    import sac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SETS   = 16,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int SET_W  = $clog2(SETS);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int BYTE_W = 2;
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W - BYTE_W;
    localparam int DEPTH  = SETS * NUM_WAYS * WORDS;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

    // Incoming address fields.
    logic [TAG_W-1:0] in_tag;
    logic [SET_W-1:0] in_set;
    logic [OFF_W-1:0] in_off;
    assign in_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
    assign in_set = cpu_req_addr[BYTE_W+OFF_W +: SET_W];
    assign in_off = cpu_req_addr[BYTE_W +: OFF_W];

    ctl_state_e        st_q;
    logic              wr_q;
    logic [TAG_W-1:0]  tag_q;
    logic [SET_W-1:0]  set_q;
    logic [OFF_W-1:0]  off_q;
    logic [DATA_W-1:0] wdat_q;
    logic [WAY_W-1:0]  way_q;
    logic [TAG_W-1:0]  vtag_q;
    logic [OFF_W-1:0]  cnt_q;
    logic              resp_q;
    logic [DATA_W-1:0] rdat_q;

    logic              accept;
    logic [SET_W-1:0]  lk_set;
    logic [NUM_WAYS-1:0] hit_vec, valid_vec, dirty_vec;
    logic [TAG_W-1:0]  way_tag [NUM_WAYS];
    logic              lk_hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  tree_way;
    logic [WAY_W-1:0]  vic_way;
    logic              vic_has_free;

    logic              fill_en, dirty_en, touch_en, dat_we;
    logic [WAY_W-1:0]  touch_way;
    logic [SET_W-1:0]  touch_set;
    logic [IDX_W-1:0]  dat_ridx, dat_widx;
    logic [DATA_W-1:0] dat_rdata, dat_wdata;

    assign cpu_req_ready = (st_q == ST_IDLE);
    assign accept        = cpu_req_valid && cpu_req_ready;
    assign lk_set        = (st_q == ST_IDLE) ? in_set : set_q;
    assign lk_hit        = |hit_vec;

    sac_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_set    (lk_set),
        .lk_tag    (in_tag),
        .hit_vec   (hit_vec),
        .valid_vec (valid_vec),
        .dirty_vec (dirty_vec),
        .way_tag   (way_tag),
        .fill_en   (fill_en),
        .fill_set  (set_q),
        .fill_way  (way_q),
        .fill_tag  (tag_q),
        .dirty_en  (dirty_en),
        .dirty_set (in_set),
        .dirty_way (hit_way)
    );

    sac_data_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_idx  (dat_ridx),
        .rd_data (dat_rdata),
        .wr_en   (dat_we),
        .wr_idx  (dat_widx),
        .wr_data (dat_wdata)
    );

    sac_lru_state #(.SETS(SETS)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_set     (lk_set),
        .victim_way (tree_way),
        .touch_en   (touch_en),
        .touch_set  (touch_set),
        .touch_way  (touch_way)
    );

    // Encode the hitting way; at most one way matches.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    // Victim: lowest invalid way, else the tree's choice.
    always_comb begin
        vic_way      = tree_way;
        vic_has_free = 1'b0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid_vec[w]) begin
                vic_way      = WAY_W'(w);
                vic_has_free = 1'b1;
            end
        end
    end

    // Storage update strobes derived from state and handshakes.
    always_comb begin
        fill_en   = 1'b0;
        dirty_en  = 1'b0;
        touch_en  = 1'b0;
        touch_way = hit_way;
        touch_set = in_set;
        dat_we    = 1'b0;
        dat_widx  = {in_set, hit_way, in_off};
        dat_wdata = cpu_req_wdata;
        if (st_q == ST_IDLE) begin
            dat_ridx = {in_set, hit_way, in_off};
            if (accept && lk_hit) begin
                touch_en = 1'b1;
                dat_we   = cpu_req_write;
                dirty_en = cpu_req_write;
            end
        end else begin
            dat_ridx = {set_q, way_q, cnt_q};
        end
        if (st_q == ST_FILL && mem_ack) begin
            dat_we    = 1'b1;
            dat_widx  = {set_q, way_q, cnt_q};
            dat_wdata = mem_rdata;
            if (cnt_q == LAST_OFF) begin
                fill_en   = 1'b1;
                touch_en  = 1'b1;
                touch_way = way_q;
                touch_set = set_q;
            end
        end
    end

    // Memory port driven from held request registers.
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        case (st_q)
            ST_EVICT: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {vtag_q, set_q, cnt_q, {BYTE_W{1'b0}}};
                mem_req_wdata = dat_rdata;
            end
            ST_FILL: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {tag_q, set_q, cnt_q, {BYTE_W{1'b0}}};
            end
            ST_WTHRU: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {tag_q, set_q, off_q, {BYTE_W{1'b0}}};
                mem_req_wdata = wdat_q;
            end
            default: ;
        endcase
    end

    // Sequencer: lookup, write-back, refill and write-through steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            resp_q <= 1'b0;
            rdat_q <= '0;
            cnt_q  <= '0;
        end else begin
            resp_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        wr_q   <= cpu_req_write;
                        tag_q  <= in_tag;
                        set_q  <= in_set;
                        off_q  <= in_off;
                        wdat_q <= cpu_req_wdata;
                        if (lk_hit) begin
                            resp_q <= 1'b1;
                            rdat_q <= cpu_req_write ? '0 : dat_rdata;
                        end else if (cpu_req_write) begin
                            st_q <= ST_WTHRU;
                        end else begin
                            way_q  <= vic_way;
                            vtag_q <= way_tag[vic_way];
                            cnt_q  <= '0;
                            st_q   <= (!vic_has_free && dirty_vec[vic_way]) ? ST_EVICT : ST_FILL;
                        end
                    end
                end
                ST_EVICT: begin
                    if (mem_ack) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST_OFF) st_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == off_q) rdat_q <= mem_rdata;
                        if (cnt_q == LAST_OFF) begin
                            resp_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end
                    end
                end
                ST_WTHRU: begin
                    if (mem_ack) begin
                        resp_q <= 1'b1;
                        rdat_q <= '0;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign cpu_resp_valid = resp_q;
    assign cpu_resp_rdata = rdat_q;

endmodule

// File: rtl/sac_checker.sv
// Protocol and sequencing properties of the read cache, bound to the top.
// Assumes the lookup hit signal is only meaningful while a request is accepted.
module sac_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_req_write,
    input logic              cpu_resp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata,
    input logic              mem_ack,
    input logic              lk_hit
);

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_ack |=> mem_req_valid && $stable(mem_req_write)
            && $stable(mem_req_addr) && $stable(mem_req_wdata));

    // R2
    busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !cpu_req_ready);

    // R1
    hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && cpu_req_ready && lk_hit |=> cpu_resp_valid && !mem_req_valid);

    // R4
    wmiss_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && cpu_req_ready && cpu_req_write && !lk_hit |=> mem_req_valid && mem_req_write);

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> cpu_req_ready && !mem_req_valid && !cpu_resp_valid);

endmodule

bind sa_read_cache sac_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sac_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_req_write  (cpu_req_write),
    .cpu_resp_valid (cpu_resp_valid),
    .mem_req_valid  (mem_req_valid),
    .mem_req_write  (mem_req_write),
    .mem_req_addr   (mem_req_addr),
    .mem_req_wdata  (mem_req_wdata),
    .mem_ack        (mem_ack),
    .lk_hit         (lk_hit)
);

// File: tb/tb_sa_read_cache.sv
// Bench: behavioural cache and memory model, memory responder with
// variable latency, directed corner cases followed by a random run.
module tb_sa_read_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_write = 1'b0;
    logic [15:0] cpu_req_addr = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_resp_valid;
    logic [31:0] cpu_resp_rdata;
    logic        mem_req_valid;
    logic        mem_req_write;
    logic [15:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    sa_read_cache dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata), .cpu_resp_valid(cpu_resp_valid),
        .cpu_resp_rdata(cpu_resp_rdata), .mem_req_valid(mem_req_valid),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    typedef struct {
        bit          w;
        logic [15:0] a;
        logic [31:0] d;
    } xfer_t;

    xfer_t obs_q[$];
    xfer_t exp_q[$];
    logic [31:0] bmem [int];
    logic [31:0] gold [int];
    int n_chk = 0;
    int n_fail = 0;
    int mem_lat = 0;
    int wait_n = 0;

    // Behavioural cache model state.
    bit          m_val [16][4];
    bit          m_drt [16][4];
    logic [7:0]  m_tag [16][4];
    logic [31:0] m_dat [16][4][4];
    logic [2:0]  m_tree [16];

    function automatic logic [31:0] init_word(input logic [15:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction

    function automatic logic [31:0] mem_rd(input logic [15:0] a);
        return bmem.exists(int'(a)) ? bmem[int'(a)] : init_word(a);
    endfunction

    function automatic logic [31:0] gold_rd(input logic [15:0] a);
        return gold.exists(int'(a)) ? gold[int'(a)] : init_word(a);
    endfunction

    function automatic logic [15:0] mk(input logic [7:0] t, input int s, input int o);
        return {t, 4'(s), 2'(o), 2'b00};
    endfunction

    // Replacement tree as stated in R3.
    function automatic logic [2:0] m_touch(input logic [2:0] t, input int w);
        logic [2:0] n = t;
        if (w < 2) begin n[0] = 1'b1; n[1] = (w == 0); end
        else       begin n[0] = 1'b0; n[2] = (w == 2); end
        return n;
    endfunction

    function automatic int m_victim(input logic [2:0] t);
        if (!t[0]) return t[1] ? 1 : 0;
        return t[2] ? 3 : 2;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Memory responder: acknowledges after mem_lat waiting cycles.
    always @(negedge clk) begin
        xfer_t x;
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req_valid) begin
            if (wait_n >= mem_lat) begin
                wait_n  = 0;
                mem_ack = 1'b1;
                x.w = mem_req_write;
                x.a = mem_req_addr;
                if (mem_req_write) begin
                    bmem[int'(mem_req_addr)] = mem_req_wdata;
                    x.d = mem_req_wdata;
                end else begin
                    mem_rdata = mem_rd(mem_req_addr);
                    x.d = mem_rdata;
                end
                obs_q.push_back(x);
            end else begin
                wait_n++;
            end
        end
    end

    // Model one request: expected traffic, read value and hit flag.
    task automatic model(input bit w, input logic [15:0] a, input logic [31:0] d,
                         output logic [31:0] er, output bit hit);
        logic [7:0]  tg = a[15:8];
        int          s  = int'(a[7:4]);
        int          o  = int'(a[3:2]);
        logic [15:0] wa = {a[15:2], 2'b00};
        int hw = -1;
        int v  = -1;
        exp_q.delete();
        for (int i = 0; i < 4; i++) if (m_val[s][i] && m_tag[s][i] == tg) hw = i;
        hit = (hw >= 0);
        er  = '0;
        if (hit) begin
            if (w) begin
                m_dat[s][hw][o] = d;
                m_drt[s][hw] = 1'b1;
                gold[int'(wa)] = d;
            end else begin
                er = gold_rd(wa);
            end
            m_tree[s] = m_touch(m_tree[s], hw);
        end else if (w) begin
            exp_q.push_back('{1'b1, wa, d});
            gold[int'(wa)] = d;
        end else begin
            for (int i = 3; i >= 0; i--) if (!m_val[s][i]) v = i;
            if (v < 0) v = m_victim(m_tree[s]);
            if (m_val[s][v] && m_drt[s][v])
                for (int k = 0; k < 4; k++)
                    exp_q.push_back('{1'b1, mk(m_tag[s][v], s, k), m_dat[s][v][k]});
            for (int k = 0; k < 4; k++) begin
                exp_q.push_back('{1'b0, mk(tg, s, k), 32'h0});
                m_dat[s][v][k] = gold_rd(mk(tg, s, k));
            end
            m_val[s][v] = 1'b1;
            m_drt[s][v] = 1'b0;
            m_tag[s][v] = tg;
            m_tree[s]   = m_touch(m_tree[s], v);
            er = gold_rd(wa);
        end
    endtask

    // Issue one request, wait for its response and compare with the model.
    task automatic run_req(input bit w, input logic [15:0] a, input logic [31:0] d,
                           input string req, output bit hit, output int lat);
        logic [31:0] er;
        bit busy_ok = 1'b1;
        bit tr_ok;
        model(w, a, d, er, hit);
        obs_q.delete();
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = w;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        lat = 1;
        while (!cpu_resp_valid) begin
            if (cpu_req_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        if (!w) chk(cpu_resp_rdata === er, req, "read data", cpu_resp_rdata, er);
        tr_ok = (obs_q.size() == exp_q.size());
        if (tr_ok) begin
            foreach (exp_q[i]) begin
                if (obs_q[i].w != exp_q[i].w || obs_q[i].a !== exp_q[i].a) tr_ok = 1'b0;
                if (exp_q[i].w && obs_q[i].d !== exp_q[i].d) tr_ok = 1'b0;
            end
        end
        chk(tr_ok, req, "memory traffic (count)", obs_q.size(), exp_q.size());
        if (!hit) chk(busy_ok, "R2", "ready low while busy", busy_ok, 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(cpu_req_ready === 1'b1, "R9", "ready in reset", cpu_req_ready, 1);
        chk(mem_req_valid === 1'b0, "R9", "mem idle in reset", mem_req_valid, 0);
        chk(cpu_resp_valid === 1'b0, "R9", "no response in reset", cpu_resp_valid, 0);
        for (int s = 0; s < 16; s++) begin
            m_tree[s] = '0;
            for (int i = 0; i < 4; i++) begin m_val[s][i] = 1'b0; m_drt[s][i] = 1'b0; end
        end
        gold.delete();
        foreach (bmem[k]) gold[k] = bmem[k];
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        bit hit;
        int lat;
        logic [15:0] a;
        do_reset();

        // R2: first read misses and refills in order.
        run_req(1'b0, mk(8'h01, 0, 1), 0, "R2", hit, lat);
        chk(obs_q.size() == 4 && obs_q[0].a == mk(8'h01, 0, 0), "R2", "refill starts at offset 0", obs_q[0].a, mk(8'h01, 0, 0));
        // R1: hit in the same block.
        run_req(1'b0, mk(8'h01, 0, 3), 0, "R1", hit, lat);
        chk(lat == 1, "R1", "hit latency", lat, 1);
        chk(obs_q.size() == 0, "R1", "no memory access on hit", obs_q.size(), 0);
        // R7: byte field ignored.
        run_req(1'b0, mk(8'h01, 0, 1) | 16'h3, 0, "R7", hit, lat);
        chk(hit && lat == 1, "R7", "byte bits give a hit", lat, 1);
        // R5: write hit stays local.
        run_req(1'b1, mk(8'h01, 0, 2) | 16'h1, 32'hDEAD_BEEF, "R5", hit, lat);
        chk(lat == 1 && obs_q.size() == 0, "R5", "write hit latency", lat, 1);
        run_req(1'b0, mk(8'h01, 0, 2), 0, "R5", hit, lat);
        // R4: write miss goes through, no allocation.
        mem_lat = 2;
        run_req(1'b1, mk(8'h02, 1, 0), 32'h0000_1234, "R4", hit, lat);
        chk(obs_q.size() == 1 && obs_q[0].w, "R4", "single memory write", obs_q.size(), 1);
        run_req(1'b0, mk(8'h02, 1, 0), 0, "R4", hit, lat);
        chk(!hit && obs_q.size() == 4, "R4", "later read misses", obs_q.size(), 4);
        mem_lat = 1;

        // R3 / R6: steer the tree onto a modified way in set 2.
        run_req(1'b0, mk(8'h10, 2, 0), 0, "R3", hit, lat);
        run_req(1'b0, mk(8'h11, 2, 0), 0, "R3", hit, lat);
        run_req(1'b0, mk(8'h12, 2, 0), 0, "R3", hit, lat);
        run_req(1'b1, mk(8'h12, 2, 1), 32'hCAFE_0001, "R5", hit, lat);
        run_req(1'b0, mk(8'h13, 2, 0), 0, "R3", hit, lat);
        run_req(1'b0, mk(8'h10, 2, 2), 0, "R3", hit, lat);
        run_req(1'b0, mk(8'h11, 2, 2), 0, "R3", hit, lat);
        run_req(1'b0, mk(8'h14, 2, 3), 0, "R6", hit, lat);
        chk(obs_q.size() == 8, "R6", "write-back plus refill count", obs_q.size(), 8);
        chk(obs_q.size() == 8 && obs_q[0].w && obs_q[0].a == mk(8'h12, 2, 0), "R3", "tree victim way 2", obs_q[0].a, mk(8'h12, 2, 0));
        chk(obs_q.size() == 8 && obs_q[1].d == 32'hCAFE_0001, "R6", "modified word written back", obs_q[1].d, 32'hCAFE_0001);
        chk(obs_q.size() == 8 && !obs_q[4].w, "R6", "refill after write-back", obs_q[4].w, 0);
        run_req(1'b0, mk(8'h13, 2, 1), 0, "R3", hit, lat);
        chk(hit, "R3", "untouched way kept", hit, 1);
        run_req(1'b0, mk(8'h12, 2, 1), 0, "R6", hit, lat);
        chk(!hit, "R6", "evicted block misses", hit, 0);

        // R9: reset drops a modified block.
        run_req(1'b1, mk(8'h01, 0, 0), 32'h7777_0000, "R5", hit, lat);
        do_reset();
        run_req(1'b0, mk(8'h01, 0, 0), 0, "R9", hit, lat);
        chk(!hit && obs_q.size() == 4, "R9", "read after reset misses", obs_q.size(), 4);

        // Random run over few tags per set.
        for (int n = 0; n < 400; n++) begin
            bit rw = ($urandom_range(0, 9) < 4);
            a = mk(8'($urandom_range(0, 5)), $urandom_range(0, 1), $urandom_range(0, 3))
                | 16'($urandom_range(0, 3));
            mem_lat = $urandom_range(0, 3);
            run_req(rw, a, $urandom, "R1/R2/R3/R4/R5/R6", hit, lat);
            if (hit) chk(lat == 1, "R1", "random hit latency", lat, 1);
        end
        summary();
    end

endmodule